// File: doc/BRIEF.md
# Direct-Mapped Cache with Victim Buffer

This block is a read-only first-level cache that stores one line per set. Beside it sits a small fully-associative side buffer on the refill path. The processor offers one line address at a time on a valid/ready request port. The block answers on a response port with the line data. When a line is in neither store, the block fetches it from the next memory level through a request/response refill port.

In victim mode (`MISS_MODE = 0`), a line that a refill pushes out of the direct-mapped store is kept in the side buffer. A later request for that line then costs one extra cycle instead of a full fetch, and the two lines trade places. In miss-cache mode (`MISS_MODE = 1`), the side buffer instead keeps a copy of every fetched line. A buffer hit in that mode copies the line back into the direct-mapped store, and the displaced main line is dropped. The side buffer replaces its least recently used entry, but it fills empty entries first.

The controller is a four-state machine:
- IDLE accepts a request (IDLE→LOOKUP).
- LOOKUP probes both stores at once with the full line address. It returns on a main hit (LOOKUP→IDLE), moves on after a buffer hit (LOOKUP→SWAP), and otherwise moves on to a fetch (LOOKUP→FETCH).
- SWAP answers from the buffer and exchanges or copies the lines (SWAP→IDLE).
- FETCH holds a next-level read until the data returns, then answers and refills (FETCH→IDLE).

Top module: `victim_assist_cache`

## Requirements
- R1: After reset `req_ready` is 1 and `rsp_valid` and `mem_req_valid` are 0. Both stores are empty, so the first request to any address issues a next-level read.
- R2: A request whose line is in the direct-mapped store gets `rsp_valid` with the correct line one cycle after the acceptance edge, and `mem_req_valid` is never raised.
- R3: A request that misses the direct-mapped store but hits the side buffer gets `rsp_valid` two cycles after acceptance, one cycle later than a main hit. It carries the correct line and raises no next-level read.
- R4: A request that misses both stores raises `mem_req_valid` with `mem_req_addr` equal to the request address. Both stay steady until `mem_rsp_valid`. `rsp_valid` is given in that same cycle with `mem_rsp_data`.
- R5: In victim mode, a refill that displaces a valid line puts the displaced line into the side buffer and not the requested line. A later request for the displaced line is a buffer hit.
- R6: In victim mode, a buffer hit exchanges the two lines. The requested line becomes a main hit, and the line it displaced becomes a buffer hit.
- R7: In miss-cache mode, every refill also puts the fetched line in the side buffer. A buffer hit copies the line into the direct-mapped store, keeps it in the buffer, and drops the displaced main line.
- R8: The side buffer fills an empty entry before it replaces a valid one. When it is full, it replaces the entry least recently written or hit.
- R9: Both stores match on the full line address. Lines with the same set index but different tags never hit for each other, and the side buffer holds lines from any sets together.
- R10: `req_ready` is 0 from acceptance until the response cycle, so only one request is in flight, and it is 1 again in the cycle after `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor offers a line address |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_addr | input | ADDR_W | Requested line address (low IDX_W bits are the set index) |
| rsp_valid | output | 1 | Response line is valid this cycle |
| rsp_data | output | LINE_W | Response line data |
| mem_req_valid | output | 1 | Next-level read pending |
| mem_req_addr | output | ADDR_W | Line address of the next-level read |
| mem_rsp_valid | input | 1 | Next-level read data valid |
| mem_rsp_data | input | LINE_W | Next-level read data |

## Verification
The three-way split between main hit, buffer hit and full miss shows up at the ports. It appears as the number of cycles to `rsp_valid` and as whether a next-level read appears, so each request's class is checked against a bench model of both stores. A wrong valid bit, a bad swap, or a wrong choice of replaced entry does not show when it happens. It shows on the next request to the affected line, as a class one step off or as wrong data. For that reason, the directed sequences revisit lines right after conflicts and evictions, and the random stream keeps a small address pool so that such revisits are frequent.

// File: rtl/vac_pkg.sv
package vac_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_SWAP,
        ST_FETCH
    } vac_state_e;

    function automatic int sel_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/vac_direct_array.sv
module vac_direct_array #(
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 3,
    parameter int LINE_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [IDX_W-1:0]        idx,
    output logic                    rd_valid,
    output logic [ADDR_W-IDX_W-1:0] rd_tag,
    output logic [LINE_W-1:0]       rd_data,
    input  logic                    wr_en,
    input  logic [ADDR_W-IDX_W-1:0] wr_tag,
    input  logic [LINE_W-1:0]       wr_data
);
    localparam int SETS  = 1 << IDX_W;
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [SETS-1:0]   valid_q;
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [LINE_W-1:0] data_q [SETS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[idx]  <= wr_tag;
            data_q[idx] <= wr_data;
        end
    end

    assign rd_valid = valid_q[idx];
    assign rd_tag   = tag_q[idx];
    assign rd_data  = data_q[idx];

endmodule

// File: rtl/vac_side_buffer.sv
module vac_side_buffer #(
    parameter int ADDR_W = 12,
    parameter int LINE_W = 32,
    parameter int DEPTH  = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [ADDR_W-1:0]                   probe_addr,
    output logic                                hit,
    output logic [vac_pkg::sel_width(DEPTH)-1:0] hit_sel,
    output logic [LINE_W-1:0]                   hit_data,
    output logic [vac_pkg::sel_width(DEPTH)-1:0] repl_sel,
    input  logic                                upd_en,
    input  logic                                upd_write,
    input  logic [vac_pkg::sel_width(DEPTH)-1:0] upd_sel,
    input  logic [ADDR_W-1:0]                   upd_addr,
    input  logic [LINE_W-1:0]                   upd_data
);
    localparam int SEL_W = vac_pkg::sel_width(DEPTH);

    logic [DEPTH-1:0]  valid_q;
    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [LINE_W-1:0] data_q [DEPTH];
    logic [SEL_W-1:0]  age_q  [DEPTH];
    logic [DEPTH-1:0]  hit_vec;
    logic              free_found;
    logic [SEL_W-1:0]  best_age;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign hit_vec[i] = valid_q[i] && (addr_q[i] == probe_addr);
    end

    assign hit = |hit_vec;

    always_comb begin
        hit_sel = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (hit_vec[i]) hit_sel = SEL_W'(i);
        end
    end

    assign hit_data = data_q[hit_sel];

    // Empty entry first (lowest index), else the oldest valid entry.
    always_comb begin
        repl_sel   = '0;
        free_found = 1'b0;
        best_age   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!valid_q[i] && !free_found) begin
                repl_sel   = SEL_W'(i);
                free_found = 1'b1;
            end
        end
        if (!free_found) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (age_q[i] >= best_age) begin
                    best_age = age_q[i];
                    repl_sel = SEL_W'(i);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int j = 0; j < DEPTH; j++) age_q[j] <= '0;
        end else if (upd_en) begin
            for (int j = 0; j < DEPTH; j++) begin
                if (upd_sel == SEL_W'(j)) begin
                    age_q[j] <= '0;
                    if (upd_write) valid_q[j] <= 1'b1;
                end else if (valid_q[j] &&
                             (!valid_q[upd_sel] || age_q[j] < age_q[upd_sel])) begin
                    age_q[j] <= age_q[j] + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (upd_en && upd_write) begin
            addr_q[upd_sel] <= upd_addr;
            data_q[upd_sel] <= upd_data;
        end
    end

    a_r9_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    a_r8_free_first: assert property (@(posedge clk) disable iff (!rst_n)
        !(&valid_q) |-> !valid_q[repl_sel]);

    for (genvar i = 0; i < DEPTH; i++) begin : g_age_chk
        a_r8_age_rank: assert property (@(posedge clk) disable iff (!rst_n)
            valid_q[i] |-> (int'(age_q[i]) < $countones(valid_q)));
    end

endmodule

// File: rtl/vac_ctrl.sv
module vac_ctrl #(
    parameter int ADDR_W    = 12,
    parameter int IDX_W     = 3,
    parameter int LINE_W    = 32,
    parameter int DEPTH     = 4,
    parameter bit MISS_MODE = 1'b0
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 req_valid,
    output logic                                 req_ready,
    input  logic [ADDR_W-1:0]                    req_addr,
    output logic                                 rsp_valid,
    output logic [LINE_W-1:0]                    rsp_data,
    output logic                                 mem_req_valid,
    output logic [ADDR_W-1:0]                    mem_req_addr,
    input  logic                                 mem_rsp_valid,
    input  logic [LINE_W-1:0]                    mem_rsp_data,
    output logic [ADDR_W-1:0]                    probe_addr,
    input  logic                                 main_valid,
    input  logic [ADDR_W-IDX_W-1:0]              main_tag,
    input  logic [LINE_W-1:0]                    main_data,
    output logic                                 main_wr_en,
    output logic [LINE_W-1:0]                    main_wr_data,
    input  logic                                 buf_hit,
    input  logic [vac_pkg::sel_width(DEPTH)-1:0] buf_hit_sel,
    input  logic [LINE_W-1:0]                    buf_hit_data,
    input  logic [vac_pkg::sel_width(DEPTH)-1:0] buf_repl_sel,
    output logic                                 buf_upd_en,
    output logic                                 buf_upd_write,
    output logic [vac_pkg::sel_width(DEPTH)-1:0] buf_upd_sel,
    output logic [ADDR_W-1:0]                    buf_upd_addr,
    output logic [LINE_W-1:0]                    buf_upd_data
);
    import vac_pkg::*;

    localparam int TAG_W = ADDR_W - IDX_W;

    vac_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [TAG_W-1:0]  cur_tag;
    logic [IDX_W-1:0]  cur_idx;
    logic              main_hit;
    logic [ADDR_W-1:0] victim_addr;

    assign cur_tag      = addr_q[ADDR_W-1:IDX_W];
    assign cur_idx      = addr_q[IDX_W-1:0];
    assign main_hit     = main_valid && (main_tag == cur_tag);
    assign victim_addr  = {main_tag, cur_idx};
    assign probe_addr   = addr_q;
    assign mem_req_addr = addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req_valid) addr_q <= req_addr;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_LOOKUP;
            ST_LOOKUP: state_d = main_hit ? ST_IDLE : (buf_hit ? ST_SWAP : ST_FETCH);
            ST_SWAP:   state_d = ST_IDLE;
            ST_FETCH:  if (mem_rsp_valid) state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready     = 1'b0;
        rsp_valid     = 1'b0;
        rsp_data      = main_data;
        mem_req_valid = 1'b0;
        main_wr_en    = 1'b0;
        main_wr_data  = mem_rsp_data;
        buf_upd_en    = 1'b0;
        buf_upd_write = 1'b0;
        buf_upd_sel   = buf_repl_sel;
        buf_upd_addr  = victim_addr;
        buf_upd_data  = main_data;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_LOOKUP: rsp_valid = main_hit;
            ST_SWAP: begin
                rsp_valid    = 1'b1;
                rsp_data     = buf_hit_data;
                main_wr_en   = 1'b1;
                main_wr_data = buf_hit_data;
                buf_upd_en   = 1'b1;
                buf_upd_sel  = buf_hit_sel;
                buf_upd_write = !MISS_MODE;
            end
            ST_FETCH: begin
                mem_req_valid = 1'b1;
                if (mem_rsp_valid) begin
                    rsp_valid  = 1'b1;
                    rsp_data   = mem_rsp_data;
                    main_wr_en = 1'b1;
                    if (MISS_MODE) begin
                        buf_upd_en    = 1'b1;
                        buf_upd_write = 1'b1;
                        buf_upd_addr  = addr_q;
                        buf_upd_data  = mem_rsp_data;
                    end else if (main_valid) begin
                        buf_upd_en    = 1'b1;
                        buf_upd_write = 1'b1;
                    end
                end
            end
        endcase
    end

    a_r4_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_rsp_valid) |=> (mem_req_valid && $stable(mem_req_addr)));

    a_r6_swap_has_victim: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SWAP) |-> main_valid);

    a_r3_one_extra_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOKUP && !main_hit && buf_hit) |=> (rsp_valid && !mem_req_valid));

    a_r2_no_fetch_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOKUP && main_hit) |=> (!mem_req_valid && req_ready));

    a_r10_ready_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> req_ready);

endmodule

// File: rtl/victim_assist_cache.sv
module victim_assist_cache #(
    parameter int ADDR_W    = 12,
    parameter int IDX_W     = 3,
    parameter int LINE_W    = 32,
    parameter int BUF_DEPTH = 4,
    parameter bit MISS_MODE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic [LINE_W-1:0] rsp_data,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [LINE_W-1:0] mem_rsp_data
);
    localparam int SEL_W = vac_pkg::sel_width(BUF_DEPTH);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [ADDR_W-1:0] probe_addr;
    logic              main_valid;
    logic [TAG_W-1:0]  main_tag;
    logic [LINE_W-1:0] main_data;
    logic              main_wr_en;
    logic [LINE_W-1:0] main_wr_data;
    logic              buf_hit;
    logic [SEL_W-1:0]  buf_hit_sel;
    logic [LINE_W-1:0] buf_hit_data;
    logic [SEL_W-1:0]  buf_repl_sel;
    logic              buf_upd_en;
    logic              buf_upd_write;
    logic [SEL_W-1:0]  buf_upd_sel;
    logic [ADDR_W-1:0] buf_upd_addr;
    logic [LINE_W-1:0] buf_upd_data;

    vac_ctrl #(
        .ADDR_W(ADDR_W), .IDX_W(IDX_W), .LINE_W(LINE_W),
        .DEPTH(BUF_DEPTH), .MISS_MODE(MISS_MODE)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .probe_addr(probe_addr),
        .main_valid(main_valid), .main_tag(main_tag), .main_data(main_data),
        .main_wr_en(main_wr_en), .main_wr_data(main_wr_data),
        .buf_hit(buf_hit), .buf_hit_sel(buf_hit_sel), .buf_hit_data(buf_hit_data),
        .buf_repl_sel(buf_repl_sel),
        .buf_upd_en(buf_upd_en), .buf_upd_write(buf_upd_write),
        .buf_upd_sel(buf_upd_sel), .buf_upd_addr(buf_upd_addr),
        .buf_upd_data(buf_upd_data)
    );

    vac_direct_array #(
        .ADDR_W(ADDR_W), .IDX_W(IDX_W), .LINE_W(LINE_W)
    ) u_main (
        .clk(clk), .rst_n(rst_n),
        .idx(probe_addr[IDX_W-1:0]),
        .rd_valid(main_valid), .rd_tag(main_tag), .rd_data(main_data),
        .wr_en(main_wr_en), .wr_tag(probe_addr[ADDR_W-1:IDX_W]),
        .wr_data(main_wr_data)
    );

    vac_side_buffer #(
        .ADDR_W(ADDR_W), .LINE_W(LINE_W), .DEPTH(BUF_DEPTH)
    ) u_side (
        .clk(clk), .rst_n(rst_n),
        .probe_addr(probe_addr),
        .hit(buf_hit), .hit_sel(buf_hit_sel), .hit_data(buf_hit_data),
        .repl_sel(buf_repl_sel),
        .upd_en(buf_upd_en), .upd_write(buf_upd_write), .upd_sel(buf_upd_sel),
        .upd_addr(buf_upd_addr), .upd_data(buf_upd_data)
    );

endmodule

// File: tb/sim_victim_assist_cache.sv
`timescale 1ns/100ps
module sim_victim_assist_cache;
    localparam int AW   = 12;
    localparam int IW   = 3;
    localparam int LW   = 32;
    localparam int DEP  = 4;
    localparam int SETS = 1 << IW;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst_n;
    logic          req_valid;
    logic [AW-1:0] req_addr;
    logic [1:0]    ready_w, rspv_w, mreq_w, mrsp_w;
    logic [LW-1:0] rspd_w  [2];
    logic [AW-1:0] maddr_w [2];
    logic [LW-1:0] mdata_w [2];
    int            mcnt    [2];

    int n_chk = 0;
    int n_bad = 0;

    function automatic logic [LW-1:0] line_of(input logic [AW-1:0] a);
        logic [31:0] x;
        x = {20'h0, a} * 32'h9E37_79B1;
        return x ^ 32'h5A5A_0000;
    endfunction

    // u0: victim mode, u1: miss-cache mode
    victim_assist_cache #(.MISS_MODE(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(ready_w[0]),
        .req_addr(req_addr), .rsp_valid(rspv_w[0]), .rsp_data(rspd_w[0]),
        .mem_req_valid(mreq_w[0]), .mem_req_addr(maddr_w[0]),
        .mem_rsp_valid(mrsp_w[0]), .mem_rsp_data(mdata_w[0]));

    victim_assist_cache #(.MISS_MODE(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(ready_w[1]),
        .req_addr(req_addr), .rsp_valid(rspv_w[1]), .rsp_data(rspd_w[1]),
        .mem_req_valid(mreq_w[1]), .mem_req_addr(maddr_w[1]),
        .mem_rsp_valid(mrsp_w[1]), .mem_rsp_data(mdata_w[1]));

    for (genvar m = 0; m < 2; m++) begin : g_mem
        assign mdata_w[m] = line_of(maddr_w[m]);
        always @(negedge clk) begin
            if (!mreq_w[m]) begin
                mcnt[m]   <= 0;
                mrsp_w[m] <= 1'b0;
            end else if (mcnt[m] == 2) begin
                mrsp_w[m] <= 1'b1;
                mcnt[m]   <= mcnt[m] + 1;
            end else if (!mrsp_w[m]) begin
                mcnt[m] <= mcnt[m] + 1;
            end
        end
    end

    // Bench model of both stores per mode
    logic          mv   [2][SETS];
    logic [AW-IW-1:0] mt [2][SETS];
    logic          bv   [2][DEP];
    logic [AW-1:0] ba   [2][DEP];
    int            bage [2][DEP];

    task automatic model_clear();
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < SETS; s++) begin mv[m][s] = 1'b0; mt[m][s] = '0; end
            for (int e = 0; e < DEP; e++) begin bv[m][e] = 1'b0; ba[m][e] = '0; bage[m][e] = 0; end
        end
    endtask

    task automatic model_touch(input int m, input int s);
        for (int j = 0; j < DEP; j++)
            if (j != s && bv[m][j] && (!bv[m][s] || bage[m][j] < bage[m][s]))
                bage[m][j]++;
        bage[m][s] = 0;
        bv[m][s]   = 1'b1;
    endtask

    function automatic int model_repl(input int m);
        int best;
        for (int j = 0; j < DEP; j++) if (!bv[m][j]) return j;
        best = 0;
        for (int j = 1; j < DEP; j++) if (bage[m][j] > bage[m][best]) best = j;
        return best;
    endfunction

    // cls: 0 main hit, 1 buffer hit, 2 full miss
    task automatic model_access(input int m, input logic [AW-1:0] a, output int cls);
        logic [IW-1:0]    ix;
        logic [AW-IW-1:0] tg;
        int s;
        ix = a[IW-1:0];
        tg = a[AW-1:IW];
        s  = -1;
        if (mv[m][ix] && mt[m][ix] == tg) begin
            cls = 0;
        end else begin
            for (int j = 0; j < DEP; j++) if (bv[m][j] && ba[m][j] == a) s = j;
            if (s >= 0) begin
                cls = 1;
                if (m == 0) ba[m][s] = {mt[m][ix], ix};
                model_touch(m, s);
            end else begin
                cls = 2;
                if (m == 1) begin
                    s = model_repl(m);
                    ba[m][s] = a;
                    model_touch(m, s);
                end else if (mv[m][ix]) begin
                    s = model_repl(m);
                    ba[m][s] = {mt[m][ix], ix};
                    model_touch(m, s);
                end
            end
            mv[m][ix] = 1'b1;
            mt[m][ix] = tg;
        end
    endtask

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic run_req(input logic [AW-1:0] a, input string rq);
        int            lat  [2];
        bit            seen [2];
        bit            aok  [2];
        bit            done [2];
        logic [LW-1:0] dat  [2];
        int            ecls [2];
        int            acls;
        bit            busy_ok;
        int            c;
        @(negedge clk); #1;
        req_valid = 1'b1;
        req_addr  = a;
        @(posedge clk); #1;
        req_valid = 1'b0;
        busy_ok = 1'b1;
        for (int m = 0; m < 2; m++) begin
            lat[m] = 0; seen[m] = 1'b0; aok[m] = 1'b1; done[m] = 1'b0; dat[m] = '0;
        end
        c = 0;
        while (!(done[0] && done[1]) && c < 60) begin
            @(negedge clk); #1;
            c++;
            for (int m = 0; m < 2; m++) begin
                if (!done[m]) begin
                    if (ready_w[m]) busy_ok = 1'b0;
                    if (mreq_w[m]) begin
                        seen[m] = 1'b1;
                        if (maddr_w[m] != a) aok[m] = 1'b0;
                    end
                    if (rspv_w[m]) begin
                        done[m] = 1'b1;
                        lat[m]  = c;
                        dat[m]  = rspd_w[m];
                    end
                end
            end
        end
        chk(c < 60, rq, "response timeout", c, 60);
        chk(busy_ok, "R10", "req_ready low while busy", {31'b0, busy_ok}, 1);
        for (int m = 0; m < 2; m++) begin
            model_access(m, a, ecls[m]);
            acls = seen[m] ? 2 : (lat[m] == 1 ? 0 : (lat[m] == 2 ? 1 : 3));
            chk(acls == ecls[m], rq, (m == 0) ? "victim-mode class" : "miss-mode class",
                acls, ecls[m]);
            chk(dat[m] == line_of(a), "R2/R3/R4 data", (m == 0) ? "victim-mode data" : "miss-mode data",
                dat[m], line_of(a));
            if (seen[m]) chk(aok[m], "R4", "next-level address", maddr_w[m], a);
        end
    endtask

    function automatic logic [AW-1:0] mk(input int tag, input int idx);
        return AW'((tag << IW) | idx);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n     = 1'b0;
        req_valid = 1'b0;
        req_addr  = '0;
        model_clear();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        for (int m = 0; m < 2; m++) begin
            chk(ready_w[m] == 1'b1, "R1", "req_ready after reset", ready_w[m], 1);
            chk(rspv_w[m] == 1'b0, "R1", "rsp_valid after reset", rspv_w[m], 0);
            chk(mreq_w[m] == 1'b0, "R1", "mem_req_valid after reset", mreq_w[m], 0);
        end

        // Conflict ping-pong in set 0
        run_req(mk(1, 0), "R1");
        run_req(mk(1, 0), "R2");
        run_req(mk(2, 0), "R4");
        run_req(mk(1, 0), "R5");
        run_req(mk(1, 0), "R6");
        run_req(mk(2, 0), "R6");
        run_req(mk(2, 0), "R7");
        run_req(mk(3, 0), "R9");
        run_req(mk(1, 1), "R9");

        // Overflow the side buffer through one set, then revisit
        for (int t = 4; t <= 10; t++) run_req(mk(t, 2), "R8");
        for (int t = 4; t <= 10; t++) run_req(mk(t, 2), "R8");
        run_req(mk(9, 2), "R8");
        run_req(mk(4, 2), "R8");

        // Random stream over a small pool
        void'($urandom(32'd20240611));
        for (int k = 0; k < 400; k++) begin
            int t;
            int i;
            t = int'($urandom % 6);
            i = int'($urandom % 4);
            run_req(mk(t, i), "R9");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule